// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

This block takes an incoming Ethernet frame, presented one byte per valid cycle with start and end markers, and decides from the destination address whether to keep it. A kept frame is written into a circular buffer memory. The memory is organised in 256-byte pages and lies between a start page and a stop page. Every stored frame begins on a page boundary with a four-byte header. The header gives the receive status, the page where the next frame will begin, and the stored length. The frame bytes follow the header.

The ring limits, the software read boundary, the current write page, the station address, the 64-bit multicast table and three filter enables come from a register block outside this block. When a frame has been stored, the block pulses `rxOk` for one cycle and presents the new current page on `nextCurPage`, so that the register block can take it.

The first six destination bytes are held in a register until the filter decision is known. A rejected frame therefore never touches memory. The header and the held destination bytes are written once the frame has ended. The input stream must stay idle from the end of a frame until `rxOk` or the drop. A start marker that arrives while a frame is being handled is ignored.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame is refused, with no memory write and no `rxOk`, if `rxStop` is high at its first byte or if the free space is under 1518 bytes. When `curPage` is below `boundaryPage`, free space is 256*(boundary-cur). Otherwise it is 256*((stop-start)-(cur-boundary)).
- R2: With `promiscuous` high, every frame is accepted whatever its destination.
- R3: A destination of all ones (broadcast) is accepted only when `acceptBcast` is high.
- R4: A destination whose first byte has bit 0 set and that is not broadcast is a multicast destination. It is accepted only when `acceptMcast` is high and `mcastTable[idx]` is 1. That bit is byte idx[5:3], bit idx[2:0] of the table. idx is bits 31:26 of a CRC-32 (polynomial 0x04C11DB7, seed all ones, shifted left, each byte taken LSB first, no final inversion) over the six destination bytes.
- R5: Any other destination is accepted only when all six bytes equal `stationAddr`, whose bits 7:0 match the first byte received.
- R6: A frame shorter than 60 bytes is stored padded with zero bytes to 60 bytes. The stored length field is the padded size plus 4.
- R7: The header at byte 0 of the start page holds, in this order: the status (0x01, or 0x21 when the first destination byte has bit 0 set), the next page, the length low byte and the length high byte.
- R8: The next page is the current page plus floor((length+4+255)/256). If the result is at or above the stop page, the ring size (stop-start) is subtracted from it.
- R9: Frame byte k is written at page address cur*256+4+k. An address that reaches stop*256 wraps to start*256, and every write lies inside the ring.
- R10: After reset `memWe`, `rxOk` and `nextCurPage` are 0. `rxOk` is a one-cycle pulse that comes with the last header write and carries the next page on `nextCurPage`.
- R11: A frame that ends within its first six bytes is discarded with no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Frame byte valid this cycle |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame |
| inData | input | 8 | Frame byte |
| rxStop | input | 1 | Receiver stopped; refuse new frames |
| ringStartPage | input | 8 | First page of the ring |
| ringStopPage | input | 8 | Page one past the end of the ring |
| boundaryPage | input | 8 | Page up to which software has not yet read |
| curPage | input | 8 | Page where the next frame is written |
| stationAddr | input | 48 | Own unicast address, first byte in bits 7:0 |
| mcastTable | input | 64 | Multicast hash filter bits |
| promiscuous | input | 1 | Accept all frames |
| acceptBcast | input | 1 | Accept broadcast frames |
| acceptMcast | input | 1 | Accept hashed multicast frames |
| memWe | output | 1 | Ring memory write strobe |
| memAddr | output | 16 | Ring memory byte address |
| memData | output | 8 | Ring memory write byte |
| nextCurPage | output | 8 | Updated current page, valid with rxOk |
| rxOk | output | 1 | One-cycle frame-stored pulse |

## Verification
A wrong filter decision shows at once: the first body byte of an accepted frame is written one cycle after it arrives, and a rejected frame writes nothing at all. A miscounted length or pointer shows within ten cycles of the last byte. It appears as a wrong header byte, a wrong `nextCurPage`, or a data byte at the wrong address. A wrap error in the address pointer puts writes outside the ring or loses a byte at the top page. Frames are therefore placed so that both the data and the next page cross the stop page.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  typedef struct packed {
    logic load;     // first byte accepted into the destination holder
    logic capDest;  // further destination byte
    logic wrBody;   // store a body byte
    logic wrPad;    // store a zero pad byte
    logic wrHead;   // store a header or held destination byte
    logic finish;   // publish next page and pulse rxOk
  } ctlStrobe_t;

  typedef struct packed {
    logic roomOk;
    logic accept;
    logic destLast;
    logic shortFrame;
    logic padLast;
    logic headLast;
  } dpStatus_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DEST, S_BODY, S_PAD, S_HEAD, S_SKIP
  } rxState_e;

endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEof,
  input  dpStatus_t  stat,
  output ctlStrobe_t strb
);

  rxState_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      S_IDLE: begin
        if (inValid && inSof && !inEof) begin
          if (stat.roomOk) begin
            strb.load = 1'b1;
            nxt       = S_DEST;
          end else begin
            nxt = S_SKIP;
          end
        end
      end
      S_DEST: begin
        if (inValid) begin
          if (inEof) begin
            nxt = S_IDLE;            // ended inside the destination field
          end else begin
            strb.capDest = 1'b1;
            if (stat.destLast) nxt = S_BODY;
          end
        end
      end
      S_BODY: begin
        if (!stat.accept) begin
          nxt = (inValid && inEof) ? S_IDLE : S_SKIP;
        end else if (inValid) begin
          strb.wrBody = 1'b1;
          if (inEof) nxt = stat.shortFrame ? S_PAD : S_HEAD;
        end
      end
      S_PAD: begin
        strb.wrPad = 1'b1;
        if (stat.padLast) nxt = S_HEAD;
      end
      S_HEAD: begin
        strb.wrHead = 1'b1;
        if (stat.headLast) begin
          strb.finish = 1'b1;
          nxt         = S_IDLE;
        end
      end
      S_SKIP: begin
        if (inValid && inEof) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 1514,
  parameter int HDR_LEN = 4,
  parameter int FCS_LEN = 4,
  localparam int ADDR_W = PAGE_W + 8,
  localparam int CNT_W  = $clog2(MAX_LEN + 1) + 1,
  localparam int NEED   = MAX_LEN + FCS_LEN,
  localparam int HEAD_N = HDR_LEN + 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [7:0]        inData,
  input  logic              rxStop,
  input  logic [PAGE_W-1:0] ringStartPage,
  input  logic [PAGE_W-1:0] ringStopPage,
  input  logic [PAGE_W-1:0] boundaryPage,
  input  logic [PAGE_W-1:0] curPage,
  input  logic [47:0]       stationAddr,
  input  logic [63:0]       mcastTable,
  input  logic              promiscuous,
  input  logic              acceptBcast,
  input  logic              acceptMcast,
  output dpStatus_t         stat,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [PAGE_W-1:0] nextCurPage,
  output logic              rxOk
);

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ b[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  logic [PAGE_W-1:0] basePage;
  logic [CNT_W-1:0]  cnt;
  logic [47:0]       destReg;
  logic [31:0]       crcReg;
  logic [ADDR_W-1:0] ptr, hPtr;
  logic [3:0]        hIdx;

  // ring geometry and free space
  logic [ADDR_W-1:0] startAddr, stopAddr, ptrNext, hPtrNext;
  logic [PAGE_W:0]   ringPg, availPg;
  logic [ADDR_W:0]   availBytes;
  assign startAddr = {ringStartPage, 8'h00};
  assign stopAddr  = {ringStopPage, 8'h00};
  assign ringPg    = {1'b0, ringStopPage} - {1'b0, ringStartPage};
  assign ptrNext   = (ptr + 1'b1 == stopAddr) ? startAddr : ptr + 1'b1;
  assign hPtrNext  = (hPtr + 1'b1 == stopAddr) ? startAddr : hPtr + 1'b1;

  always_comb begin
    if (curPage < boundaryPage)
      availPg = {1'b0, boundaryPage} - {1'b0, curPage};
    else
      availPg = ringPg - ({1'b0, curPage} - {1'b0, boundaryPage});
  end
  assign availBytes = {availPg, 8'h00};

  // address filter
  logic isBcast, isMcast, mcastHit, accept;
  logic [5:0] hashIdx;
  assign hashIdx  = crcReg[31:26];
  assign mcastHit = mcastTable[hashIdx];
  assign isBcast  = &destReg;
  assign isMcast  = destReg[0];
  always_comb begin
    if (promiscuous)  accept = 1'b1;
    else if (isBcast) accept = acceptBcast;
    else if (isMcast) accept = acceptMcast & mcastHit;
    else              accept = (destReg == stationAddr);
  end

  // length and next page
  logic [CNT_W-1:0]  totLen;
  logic [15:0]       lenWord;
  logic [ADDR_W-1:0] pageSum;
  logic [PAGE_W:0]   nextRaw;
  logic [PAGE_W-1:0] nextPg;
  assign totLen  = cnt + CNT_W'(HDR_LEN);
  assign lenWord = 16'(totLen);
  assign pageSum = ADDR_W'(totLen) + ADDR_W'(FCS_LEN + 255);
  always_comb begin
    nextRaw = {1'b0, basePage} + {1'b0, pageSum[ADDR_W-1:8]};
    if (nextRaw >= {1'b0, ringStopPage}) nextRaw = nextRaw - ringPg;
  end
  assign nextPg = nextRaw[PAGE_W-1:0];

  // header byte select
  logic [7:0] headByte;
  logic [2:0] dIdx;
  assign dIdx = 3'(hIdx - 4'd4);
  always_comb begin
    case (hIdx)
      4'd0:    headByte = {2'b00, destReg[0], 4'b0000, 1'b1};
      4'd1:    headByte = 8'(nextPg);
      4'd2:    headByte = lenWord[7:0];
      4'd3:    headByte = lenWord[15:8];
      default: headByte = destReg[8*dIdx +: 8];
    endcase
  end

  assign stat.roomOk     = !rxStop && (availBytes >= (ADDR_W+1)'(NEED));
  assign stat.accept     = accept;
  assign stat.destLast   = (cnt == CNT_W'(5));
  assign stat.shortFrame = (cnt < CNT_W'(MIN_LEN - 1));
  assign stat.padLast    = (cnt == CNT_W'(MIN_LEN - 1));
  assign stat.headLast   = (hIdx == 4'(HEAD_N - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePage    <= '0;
      cnt         <= '0;
      destReg     <= '0;
      crcReg      <= '0;
      ptr         <= '0;
      hPtr        <= '0;
      hIdx        <= '0;
      memWe       <= 1'b0;
      memAddr     <= '0;
      memData     <= '0;
      nextCurPage <= '0;
      rxOk        <= 1'b0;
    end else begin
      memWe <= 1'b0;
      rxOk  <= 1'b0;
      if (strb.load) begin
        basePage <= curPage;
        cnt      <= CNT_W'(1);
        destReg  <= {inData, destReg[47:8]};
        crcReg   <= crcByte(32'hFFFF_FFFF, inData);
        ptr      <= {curPage, 8'h00} + ADDR_W'(HDR_LEN + 6);
        hPtr     <= {curPage, 8'h00};
        hIdx     <= '0;
      end
      if (strb.capDest) begin
        cnt     <= cnt + 1'b1;
        destReg <= {inData, destReg[47:8]};
        crcReg  <= crcByte(crcReg, inData);
      end
      if (strb.wrBody || strb.wrPad) begin
        memWe   <= 1'b1;
        memAddr <= ptr;
        memData <= strb.wrBody ? inData : 8'h00;
        ptr     <= ptrNext;
        cnt     <= cnt + 1'b1;
      end
      if (strb.wrHead) begin
        memWe   <= 1'b1;
        memAddr <= hPtr;
        memData <= headByte;
        hPtr    <= hPtrNext;
        hIdx    <= hIdx + 1'b1;
      end
      if (strb.finish) begin
        nextCurPage <= nextPg;
        rxOk        <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 1514,
  localparam int ADDR_W = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [7:0]        inData,
  input  logic              rxStop,
  input  logic [PAGE_W-1:0] ringStartPage,
  input  logic [PAGE_W-1:0] ringStopPage,
  input  logic [PAGE_W-1:0] boundaryPage,
  input  logic [PAGE_W-1:0] curPage,
  input  logic [47:0]       stationAddr,
  input  logic [63:0]       mcastTable,
  input  logic              promiscuous,
  input  logic              acceptBcast,
  input  logic              acceptMcast,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [PAGE_W-1:0] nextCurPage,
  output logic              rxOk
);

  ctlStrobe_t strb;
  dpStatus_t  stat;

  rx_ring_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .stat(stat), .strb(strb)
  );

  rx_ring_dp #(.PAGE_W(PAGE_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .rxStop(rxStop),
    .ringStartPage(ringStartPage), .ringStopPage(ringStopPage),
    .boundaryPage(boundaryPage), .curPage(curPage), .stationAddr(stationAddr),
    .mcastTable(mcastTable), .promiscuous(promiscuous), .acceptBcast(acceptBcast),
    .acceptMcast(acceptMcast), .stat(stat), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .nextCurPage(nextCurPage), .rxOk(rxOk)
  );

endmodule

// File: rtl/rx_ring_writer_checker.sv
module rx_ring_writer_checker #(
  parameter int PAGE_W  = 8,
  localparam int ADDR_W = PAGE_W + 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rxOk,
  input logic [PAGE_W-1:0] nextCurPage,
  input logic [PAGE_W-1:0] ringStartPage,
  input logic [PAGE_W-1:0] ringStopPage
);

  assert_ok_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxOk |=> !rxOk);

  assert_ok_with_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxOk |-> memWe);

  assert_addr_in_ring_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr >= {ringStartPage, 8'h00} && memAddr < {ringStopPage, 8'h00}));

  assert_next_in_ring_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxOk |-> (nextCurPage >= ringStartPage && nextCurPage < ringStopPage));

endmodule

bind rx_ring_writer rx_ring_writer_checker #(.PAGE_W(PAGE_W)) uChk (
  .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr), .rxOk(rxOk),
  .nextCurPage(nextCurPage), .ringStartPage(ringStartPage), .ringStopPage(ringStopPage)
);

// File: tb/rx_ring_writer_test.sv
`timescale 1ns/1ps
module rx_ring_writer_test;

  localparam logic [7:0]  START   = 8'h10;
  localparam logic [7:0]  STOP    = 8'h20;
  localparam logic [47:0] STATION = 48'h5544_3322_1100;
  localparam logic [47:0] OTHER   = 48'h6644_3322_1100;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCAST   = 48'h0000_005E_0001;

  typedef struct packed {
    logic [47:0] dest;
    logic [15:0] len;
    logic [2:0]  cfg;   // {promiscuous, acceptMcast, acceptBcast}
    logic        hit;   // multicast table holds the frame's hash bit
    logic        acc;
    logic [7:0]  cur;   // 0 keeps the running current page
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{STATION, 16'd64,  3'b000, 1'b0, 1'b1, 8'h10, 8'd5},  // R5 match
    '{OTHER,   16'd64,  3'b000, 1'b0, 1'b0, 8'h00, 8'd5},  // R5 mismatch
    '{OTHER,   16'd64,  3'b100, 1'b0, 1'b1, 8'h00, 8'd2},  // R2 promiscuous
    '{BCAST,   16'd64,  3'b001, 1'b0, 1'b1, 8'h00, 8'd3},  // R3 enabled
    '{BCAST,   16'd64,  3'b000, 1'b0, 1'b0, 8'h00, 8'd3},  // R3 disabled
    '{MCAST,   16'd64,  3'b010, 1'b1, 1'b1, 8'h00, 8'd4},  // R4 hash hit
    '{MCAST,   16'd64,  3'b010, 1'b0, 1'b0, 8'h00, 8'd4},  // R4 hash miss
    '{MCAST,   16'd64,  3'b000, 1'b1, 1'b0, 8'h00, 8'd4},  // R4 disabled
    '{STATION, 16'd20,  3'b000, 1'b0, 1'b1, 8'h00, 8'd6},  // R6 padding
    '{STATION, 16'd248, 3'b000, 1'b0, 1'b1, 8'h00, 8'd8},  // R8 exactly one page
    '{STATION, 16'd249, 3'b000, 1'b0, 1'b1, 8'h00, 8'd8},  // R8 spills to two pages
    '{STATION, 16'd600, 3'b000, 1'b0, 1'b1, 8'h1E, 8'd9}   // R9 data and page wrap
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inData = 8'h00;
  logic rxStop = 1'b0;
  logic [7:0] boundaryPage = START, curReg = START;
  logic [63:0] mcastTable = '0;
  logic promiscuous = 1'b0, acceptBcast = 1'b0, acceptMcast = 1'b0;
  logic memWe, rxOk;
  logic [15:0] memAddr;
  logic [7:0] memData, nextCurPage;

  rx_ring_writer uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .rxStop(rxStop), .ringStartPage(START), .ringStopPage(STOP),
    .boundaryPage(boundaryPage), .curPage(curReg), .stationAddr(STATION),
    .mcastTable(mcastTable), .promiscuous(promiscuous), .acceptBcast(acceptBcast),
    .acceptMcast(acceptMcast), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .nextCurPage(nextCurPage), .rxOk(rxOk)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, wrCount = 0;
  bit okSeen = 0;
  logic [7:0] okPage = 8'h00;
  logic [7:0] mem [4096];

  always @(negedge clk) begin
    if (memWe) begin
      mem[memAddr[11:0]] = memData;
      wrCount++;
    end
    if (rxOk) begin
      okSeen = 1;
      okPage = nextCurPage;
    end
  end

  task automatic chk(input int req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] hashOf(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      if (c[31] ^ d[n]) c = {c[30:0], 1'b0} ^ 32'h04C11DB7;
      else              c = {c[30:0], 1'b0};
    end
    return c[31:26];
  endfunction

  function automatic logic [7:0] byteAt(input logic [47:0] d, input int k, input int seed);
    if (k < 6) return d[8*k +: 8];
    return 8'((k * 7 + seed) & 255);
  endfunction

  function automatic logic [7:0] nextExp(input logic [7:0] cur, input int len);
    int l = (len < 60) ? 60 : len;
    int p = cur + ((l + 4 + 4 + 255) / 256);
    if (p >= STOP) p = p - (STOP - START);
    return 8'(p);
  endfunction

  task automatic sendFrame(input logic [47:0] d, input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      @(posedge clk); #1;
      inValid = 1'b1; inSof = (k == 0); inEof = (k == len - 1);
      inData = byteAt(d, k, seed);
    end
    @(posedge clk); #1;
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  task automatic runFrame(input logic [47:0] d, input int len, input int seed,
                          input bit acc, input int req);
    int w0 = wrCount;
    int l = (len < 60) ? 60 : len;
    int bad = 0;
    int a;
    logic [7:0] base = curReg;
    logic [7:0] nx = nextExp(curReg, len);
    logic [7:0] e;
    okSeen = 0;
    sendFrame(d, len, seed);
    repeat (120) @(posedge clk);
    #1;
    if (!acc) begin
      chk(req, "rejected frame wrote or signalled", int'(okSeen) + (wrCount - w0), 0);
      return;
    end
    chk(req, "rxOk pulse seen", int'(okSeen), 1);
    chk(req, "next page", okPage, nx);
    // R7 header layout at page start
    chk(7, "header status", mem[{base[3:0], 8'h00}], d[0] ? 8'h21 : 8'h01);
    chk(7, "header next page", mem[{base[3:0], 8'h01}], nx);
    chk(7, "header length", {mem[{base[3:0], 8'h03}], mem[{base[3:0], 8'h02}]}, l + 4);
    for (int k = 0; k < l; k++) begin
      a = base * 256 + 4 + k;
      if (a >= STOP * 256) a = a - (STOP - START) * 256;
      e = (k < len) ? byteAt(d, k, seed) : 8'h00;
      if (mem[a[11:0]] != e) bad++;
    end
    chk(req, "stored data and pad mismatches", bad, 0);
    chk(req, "write count", wrCount - w0, l + 4);
    curReg = nx;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    // R10 reset state
    chk(10, "memWe after reset", memWe, 0);
    chk(10, "rxOk after reset", rxOk, 0);
    chk(10, "nextCurPage after reset", nextCurPage, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].cur != 8'h00) curReg = VEC[i].cur;
      boundaryPage = curReg;
      {promiscuous, acceptMcast, acceptBcast} = VEC[i].cfg;
      mcastTable = (VEC[i].dest[0] && VEC[i].dest != BCAST) ?
                   (VEC[i].hit ? (64'd1 << hashOf(VEC[i].dest)) : ~(64'd1 << hashOf(VEC[i].dest))) : '0;
      runFrame(VEC[i].dest, int'(VEC[i].len), i, VEC[i].acc, int'(VEC[i].req));
    end
    {promiscuous, acceptMcast, acceptBcast} = 3'b000;
    mcastTable = '0;

    // R1 stop refuses
    curReg = 8'h12; boundaryPage = curReg; rxStop = 1'b1;
    runFrame(STATION, 64, 20, 1'b0, 1);
    rxStop = 1'b0;
    // R1 free space below boundary: 5 pages refused, 6 pages accepted
    boundaryPage = 8'h17;
    runFrame(STATION, 64, 21, 1'b0, 1);
    boundaryPage = 8'h18;
    runFrame(STATION, 64, 22, 1'b1, 1);
    // R1 free space when current page is past the boundary
    curReg = 8'h1C; boundaryPage = 8'h11;
    runFrame(STATION, 64, 23, 1'b0, 1);
    curReg = 8'h1B;
    runFrame(STATION, 64, 24, 1'b1, 1);
    // R11 frames ending inside the destination field
    boundaryPage = curReg;
    runFrame(STATION, 4, 25, 1'b0, 11);
    runFrame(STATION, 6, 26, 1'b0, 11);
    runFrame(STATION, 7, 27, 1'b1, 11);
    // R6 exactly minimum length, no padding
    boundaryPage = curReg;
    runFrame(STATION, 60, 28, 1'b1, 6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule